// File: doc/BRIEF.md
# Gated Clock Fanout Selector

This block takes two clock sources, a fast system clock and a slower scan or test clock, and picks one of them with a select input. The chosen clock passes through a gate before it reaches a set of output lanes. Each lane drives a true clock and its inverse. The gate is opened and closed by an active-low enable. A flip-flop that is clocked on the falling edge of the chosen clock captures that enable.

Because the gate can only change while the chosen clock is low, turning the outputs on or off never cuts a high phase short. Every high pulse seen at the outputs is a full high phase of the source. The select input is meant to be static during operation. It is changed only while the outputs are disabled. An asynchronous active-low reset puts the enable register in the disabled state.

There is no data path in this block, so none of its pins uses a valid/ready handshake. Every pin is a plain clock or control signal.

Top module: `gcf_clock_fanout`

## Requirements
- R1: With `sel_scan` = 0, each true output follows `clk_sys` whenever the gate is open, and is low during every low phase of `clk_sys`.
- R2: With `sel_scan` = 1, each true output follows `clk_scan` whenever the gate is open, and is low during every low phase of `clk_scan`.
- R3: If `en_n` is 0 at a falling edge of the selected clock, every true output is high during the next high phase of that clock.
- R4: If `en_n` is 1 at a falling edge of the selected clock, every true output stays at 0 until a later falling edge samples `en_n` = 0.
- R5: Toggling `en_n` between falling edges has no effect until the next falling edge. Every high pulse on a true output lasts exactly one high phase of the selected clock.
- R6: While `rst_n` is 0 the gate is closed and all true outputs are 0. After `rst_n` is released they stay 0 until the first falling edge that samples `en_n` = 0.
- R7: All `LANES` true outputs (default 5) carry the same value at all times.
- R8: Each `q_comp[i]` is the inverse of `q_true[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the enable register (reset value is closed) |
| clk_sys | input | 1 | Primary system clock (selected when `sel_scan` = 0) |
| clk_scan | input | 1 | Scan/test clock (selected when `sel_scan` = 1) |
| sel_scan | input | 1 | Source select, 0 = system clock, 1 = scan clock |
| en_n | input | 1 | Active-low gate enable, sampled on the falling edge of the selected clock |
| q_true | output | LANES | True gated clock outputs, one bit per lane |
| q_comp | output | LANES | Complement gated clock outputs, one bit per lane |

## Verification
Two functions can fall on the same edge: the enable flip-flop capturing a new value, and the gate passing or blocking the clock phase that begins right after that edge. To provoke this, `en_n` is flipped at random just after rising edges, and sometimes flipped several times within a single high phase. Both source clocks are used, with unrelated periods. The outputs are judged in two ways. A queue predicts the gate state for each high phase from the value present at the preceding falling edge. Separately, the width of every output high pulse is measured and must equal the source's high phase, which rules out any runt pulse.

// File: rtl/gcf_pkg.sv
package gcf_pkg;

  parameter int unsigned GCF_LANES = 5;

  typedef enum logic {
    SRC_SYS  = 1'b0,
    SRC_SCAN = 1'b1
  } gcf_src_e;

endpackage

// File: rtl/gcf_src_mux.sv
module gcf_src_mux
  import gcf_pkg::*;
(
  input  logic clk_sys,
  input  logic clk_scan,
  input  logic sel_scan,
  output logic clk_sel
);

  gcf_src_e src;

  assign src = gcf_src_e'(sel_scan);

  always_comb begin
    unique case (src)
      SRC_SCAN: clk_sel = clk_scan;
      default:  clk_sel = clk_sys;
    endcase
  end

endmodule

// File: rtl/gcf_en_reg.sv
module gcf_en_reg (
  input  logic rst_n,
  input  logic clk_sel,
  input  logic en_n,
  output logic gate_open
);

  // Captured while the clock is low, so the gate only moves in a low phase.
  always_ff @(negedge clk_sel or negedge rst_n) begin
    if (!rst_n) gate_open <= 1'b0;
    else        gate_open <= ~en_n;
  end

endmodule

// File: rtl/gcf_gate_fanout.sv
module gcf_gate_fanout #(
  parameter int unsigned LANES = 5
) (
  input  logic             clk_sel,
  input  logic             gate_open,
  output logic [LANES-1:0] q_true,
  output logic [LANES-1:0] q_comp
);

  logic gated;

  assign gated = clk_sel & gate_open;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign q_true[i] = gated;
    assign q_comp[i] = ~gated;
  end

endmodule

// File: rtl/gcf_clock_fanout.sv
module gcf_clock_fanout #(
  parameter int unsigned LANES = gcf_pkg::GCF_LANES
) (
  input  logic             rst_n,
  input  logic             clk_sys,
  input  logic             clk_scan,
  input  logic             sel_scan,
  input  logic             en_n,
  output logic [LANES-1:0] q_true,
  output logic [LANES-1:0] q_comp
);

  logic clk_sel;
  logic gate_open;

  gcf_src_mux u_mux (
    .clk_sys  (clk_sys),
    .clk_scan (clk_scan),
    .sel_scan (sel_scan),
    .clk_sel  (clk_sel)
  );

  gcf_en_reg u_en (
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .en_n      (en_n),
    .gate_open (gate_open)
  );

  gcf_gate_fanout #(.LANES(LANES)) u_fan (
    .clk_sel   (clk_sel),
    .gate_open (gate_open),
    .q_true    (q_true),
    .q_comp    (q_comp)
  );

endmodule

// File: rtl/gcf_clock_fanout_chk.sv
module gcf_clock_fanout_chk #(
  parameter int unsigned LANES = 5
) (
  input logic             rst_n,
  input logic             clk_sys,
  input logic             clk_scan,
  input logic             sel_scan,
  input logic             en_n,
  input logic [LANES-1:0] q_true,
  input logic [LANES-1:0] q_comp
);

  logic ck_mon;
  assign ck_mon = sel_scan ? clk_scan : clk_sys;

  // Sampled just before a falling edge, the outputs show the gate state
  // that held over the high phase which is ending.
  a_r3_open_after_fall: assert property (@(negedge ck_mon) disable iff (!rst_n)
    !en_n |=> (q_true == {LANES{1'b1}}));

  a_r4_closed_after_fall: assert property (@(negedge ck_mon) disable iff (!rst_n)
    en_n |=> (q_true == {LANES{1'b0}}));

  a_r7_lanes_agree: assert property (@(negedge ck_mon) disable iff (!rst_n)
    (q_true == {LANES{1'b0}}) || (q_true == {LANES{1'b1}}));

  a_r8_comp_inverse: assert property (@(negedge ck_mon) disable iff (!rst_n)
    q_comp == ~q_true);

  always @(negedge clk_sys) begin
    if (!rst_n) begin
      a_r6_reset_low: assert (q_true == {LANES{1'b0}});
    end
  end

endmodule

bind gcf_clock_fanout gcf_clock_fanout_chk #(.LANES(LANES)) u_chk (
  .rst_n    (rst_n),
  .clk_sys  (clk_sys),
  .clk_scan (clk_scan),
  .sel_scan (sel_scan),
  .en_n     (en_n),
  .q_true   (q_true),
  .q_comp   (q_comp)
);

// File: tb/gcf_clock_fanout_test.sv
module gcf_clock_fanout_test;

  localparam int CLK_PERIOD  = 10;
  localparam int SCAN_PERIOD = 26;
  localparam int LANES       = 5;

  logic rst_n    = 1'b0;
  logic clk_sys  = 1'b0;
  logic clk_scan = 1'b0;
  logic sel_scan = 1'b0;
  logic en_n     = 1'b0;
  logic [LANES-1:0] q_true;
  logic [LANES-1:0] q_comp;
  logic sel_ck;

  int checks = 0;
  int errors = 0;
  bit sb_on  = 1'b0;
  logic exp_q[$];

  always #(CLK_PERIOD/2)  clk_sys  = ~clk_sys;
  always #(SCAN_PERIOD/2) clk_scan = ~clk_scan;

  assign sel_ck = sel_scan ? clk_scan : clk_sys;

  gcf_clock_fanout #(.LANES(LANES)) uut (
    .rst_n    (rst_n),
    .clk_sys  (clk_sys),
    .clk_scan (clk_scan),
    .sel_scan (sel_scan),
    .en_n     (en_n),
    .q_true   (q_true),
    .q_comp   (q_comp)
  );

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic string src_req();
    return sel_scan ? "R2" : "R1";
  endfunction

  // Prediction: the value seen at each falling edge decides the next high phase.
  always @(negedge sel_ck) begin
    if (sb_on && rst_n) exp_q.push_back(~en_n);
  end

  // Low phase: the gate output must be low (R1/R2), complements inverse (R8).
  always @(negedge sel_ck) begin
    if (sb_on) begin
      #2;
      chk(q_true == '0, src_req(), $sformatf("%b", q_true), "00000");
      chk(q_comp == ~q_true, "R8", $sformatf("%b", q_comp), $sformatf("%b", ~q_true));
    end
  end

  // High phase: compare against the predicted gate state (R3/R4/R7).
  always @(posedge sel_ck) begin
    if (sb_on && exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      #2;
      chk(q_true == {LANES{e}}, e ? "R3 R7" : "R4 R7",
          $sformatf("%b", q_true), $sformatf("%b", {LANES{e}}));
      chk(q_comp == ~q_true, "R8", $sformatf("%b", q_comp), $sformatf("%b", ~q_true));
    end
  end

  // Pulse width monitor: no runt pulses (R5).
  always @(posedge q_true[0]) begin
    int  t0;
    int  half;
    bit  on;
    t0   = int'($time);
    half = sel_scan ? SCAN_PERIOD/2 : CLK_PERIOD/2;
    on   = sb_on;
    @(negedge q_true[0]);
    if (on && sb_on)
      chk((int'($time) - t0) == half, "R5",
          $sformatf("%0d", int'($time) - t0), $sformatf("%0d", half));
  end

  task automatic random_toggles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge sel_ck);
      #1;
      en_n = 1'($urandom % 2);
      if (($urandom % 4) == 0) begin
        // several flips inside one high phase; only the last one counts (R5)
        #1 en_n = ~en_n;
        #1 en_n = ~en_n;
        #1 en_n = ~en_n;
      end
    end
  endtask

  task automatic switch_source(input logic new_sel);
    @(posedge sel_ck);
    #1 en_n = 1'b1;
    repeat (3) @(negedge sel_ck);
    #3 sb_on = 1'b0;
    #(SCAN_PERIOD);
    exp_q.delete();
    sel_scan = new_sel;
    #(SCAN_PERIOD * 2);
    chk(q_true == '0, "R4", $sformatf("%b", q_true), "00000");
    @(posedge sel_ck);
    #1 sb_on = 1'b1;
  endtask

  initial begin
    // R6: reset holds the outputs low even though en_n asks to open
    repeat (3) begin
      @(posedge clk_sys);
      #2 chk(q_true == '0, "R6", $sformatf("%b", q_true), "00000");
    end
    @(posedge clk_sys);
    #1 rst_n = 1'b1;
    sb_on = 1'b1;
    #1 chk(q_true == '0, "R6", $sformatf("%b", q_true), "00000");

    // steady open on the system clock (R1, R3)
    repeat (6) @(posedge sel_ck);
    random_toggles(150);

    switch_source(1'b1);
    #1 en_n = 1'b0;
    repeat (6) @(posedge sel_ck);
    random_toggles(150);

    switch_source(1'b0);
    #1 en_n = 1'b0;
    random_toggles(100);
    @(posedge sel_ck);
    #1 en_n = 1'b1;
    repeat (4) @(posedge sel_ck);
    #2;
    sb_on = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule